// File: doc/BRIEF.md
# Dual 16-bit Reload Timer Base

This block holds two independent 16-bit up-counters. They act as the time bases for a capture/compare channel array. Each counter advances by one on every cycle in which its count strobe is high. Each timer picks one of four count sources:

- a tap of a shared free-running prescaler, with divide ratios from 8 to 1024;
- an overflow/underflow strobe that arrives from a timer outside this block;
- an edge on an asynchronous external count pin, which only timer 0 accepts;
- nothing, in which case the timer is held.

When a count strobe hits a counter that is already at 0xFFFF, the counter does not wrap to zero. It takes the value of its own reload register. A one-cycle overflow strobe is raised in that same cycle.

Software reaches the block through a simple write port, with one address for each counter, each reload register and each control register. The outputs are the two counter values, the two count strobes and the two overflow strobes. The strobes are meant to feed compare logic and interrupt logic that sit outside this block.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset both counters read 0, both reload registers hold 0, both control registers are 0 (stopped), and no count or overflow strobe is high.
- R2: Write address bit 2 selects the timer (0 or 1). Address bits [1:0] select the register: 0 is the counter, 1 is the reload register, 2 is the control register. Code 3 is ignored and changes nothing. The control register fields are: bit 0 run, bits [2:1] source, bits [5:3] divide select, bits [7:6] edge mode.
- R3: With source 0, the prescaler runs from reset. The divider is N = 8 << divide select. The count strobe is high in exactly those cycles in which the number of clock edges since reset release, modulo N, equals N-1.
- R4: Each count strobe raises the counter by one at the next clock edge when the counter is below 0xFFFF.
- R5: A count strobe while the counter equals 0xFFFF raises the overflow strobe in the same cycle and loads the reload value at the next edge. The overflow strobe is never high without the count strobe.
- R6: A reload write leaves the running count unchanged. The new value is used at the next overflow.
- R7: A counter write in the same cycle as a count strobe wins: the counter takes the written value. If the counter was at 0xFFFF, the overflow strobe stays low in that cycle.
- R8: With the run bit clear, the count strobe stays low and the counter holds its value.
- R9: With source 1, the count strobe follows the cascade input in the same cycle.
- R10: With source 2 on timer 0, the external pin passes through a two-flop synchronizer. Edge mode 1 counts rising edges, mode 2 counts falling edges, mode 3 counts both, and mode 0 counts none. A pin change made before an edge gives a strobe in the cycle that follows the second edge after it.
- R11: Source 3 never counts on either timer. Source 2 never counts on timer 1.
- R12: The two timers are independent: one timer's configuration and its strobes have no effect on the other timer's counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: bit 2 selects the timer, bits [1:0] select the register |
| wr_data | input | 16 | Write data |
| casc_stb | input | 1 | Overflow/underflow strobe from a foreign timer |
| ext_cnt | input | 1 | Asynchronous external count pin (timer 0 only) |
| cnt0 | output | 16 | Timer 0 count |
| cnt1 | output | 16 | Timer 1 count |
| tick | output | 2 | Per-timer count strobe |
| ovf | output | 2 | Per-timer overflow strobe |

## Verification
The collision that matters is a software counter write that lands in the same cycle as a count strobe. The hardest case is when the counter sits at 0xFFFF, so the write, the reload and the overflow strobe all compete.

The bench sets up this case on timer 1. It parks the counter at 0xFFFF on the cascade source, then raises the cascade strobe and a counter write in one cycle. It checks that the count strobe is high, that the overflow strobe is low, and that the written value, not the reload value, appears after the edge.

A behavioural model tracks the prescaler phase, the synchronizer and every register on each clock. It judges every other interleaving of writes, reloads and strobes.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam int CNT_W     = 16;
  localparam int SEL_W     = 3;
  localparam int PRE_BASE  = 3;
  localparam int NUM_TAPS  = 1 << SEL_W;
  localparam int ADDR_W    = 3;
  localparam int NUM_TMR   = 2;

  typedef enum logic [1:0] {SRC_PRESC = 2'd0, SRC_CASC = 2'd1,
                            SRC_EXT   = 2'd2, SRC_OFF  = 2'd3} src_e;
  typedef enum logic [1:0] {EDG_NONE = 2'd0, EDG_RISE = 2'd1,
                            EDG_FALL = 2'd2, EDG_BOTH = 2'd3} edg_e;
  typedef enum logic [1:0] {REG_CNT = 2'd0, REG_RLD = 2'd1,
                            REG_CTL = 2'd2, REG_NONE = 2'd3} reg_e;

  typedef struct packed {
    edg_e             edg;
    logic [SEL_W-1:0] div;
    src_e             src;
    logic             run;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/drt_prescaler.sv
module drt_prescaler #(
  parameter int PRE_BASE = 3,
  parameter int NUM_TAPS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [NUM_TAPS-1:0] tap
);
  localparam int PRE_W = PRE_BASE + NUM_TAPS - 1;

  logic [PRE_W-1:0] pre_q, pre_d;

  always_comb pre_d = pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // tap i fires once every 2^(PRE_BASE+i) cycles
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign tap[i] = &pre_q[PRE_BASE+i-1:0];
  end
endmodule

// File: rtl/drt_edge_sync.sv
module drt_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  always_comb begin
    rise = sync_q & ~last_q;
    fall = ~sync_q & last_q;
  end
endmodule

// File: rtl/drt_timer_core.sv
module drt_timer_core
  import drt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int NUM_TAPS = 8,
  parameter bit HAS_EXT  = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  reg_e                wr_reg,
  input  logic [CNT_W-1:0]    wr_data,
  input  logic [NUM_TAPS-1:0] tap,
  input  logic                casc_stb,
  input  logic                ext_rise,
  input  logic                ext_fall,
  output logic [CNT_W-1:0]    cnt,
  output logic                tick,
  output logic                ovf
);
  ctl_t             ctl_q, ctl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d;
  logic             cnt_wr, rld_wr, ctl_wr, cnt_en;
  logic             ext_pulse, src_pulse, at_max;

  if (HAS_EXT) begin : g_ext
    always_comb begin
      unique case (ctl_q.edg)
        EDG_RISE: ext_pulse = ext_rise;
        EDG_FALL: ext_pulse = ext_fall;
        EDG_BOTH: ext_pulse = ext_rise | ext_fall;
        default:  ext_pulse = 1'b0;
      endcase
    end
  end else begin : g_no_ext
    logic unused_ext;
    assign unused_ext = ^{ext_rise, ext_fall, ctl_q.edg};
    assign ext_pulse  = 1'b0;
  end

  always_comb begin
    unique case (ctl_q.src)
      SRC_PRESC: src_pulse = tap[ctl_q.div];
      SRC_CASC:  src_pulse = casc_stb;
      SRC_EXT:   src_pulse = ext_pulse;
      default:   src_pulse = 1'b0;
    endcase
  end

  always_comb begin
    cnt_wr = wr_en && (wr_reg == REG_CNT);
    rld_wr = wr_en && (wr_reg == REG_RLD);
    ctl_wr = wr_en && (wr_reg == REG_CTL);
    at_max = &cnt_q;
    tick   = ctl_q.run & src_pulse;
    ovf    = tick & at_max & ~cnt_wr;
    cnt_en = cnt_wr | tick;
    if (cnt_wr)      cnt_d = wr_data;
    else if (at_max) cnt_d = rld_q;
    else             cnt_d = cnt_q + 1'b1;
    rld_d = wr_data;
    ctl_d = ctl_t'(wr_data[CTL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
      ctl_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (rld_wr) rld_q <= rld_d;
      if (ctl_wr) ctl_q <= ctl_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import drt_pkg::*;
#(
  parameter int CNT_W    = drt_pkg::CNT_W,
  parameter int SEL_W    = drt_pkg::SEL_W,
  parameter int PRE_BASE = drt_pkg::PRE_BASE
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [drt_pkg::ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]          wr_data,
  input  logic                      casc_stb,
  input  logic                      ext_cnt,
  output logic [CNT_W-1:0]          cnt0,
  output logic [CNT_W-1:0]          cnt1,
  output logic [1:0]                tick,
  output logic [1:0]                ovf
);
  localparam int TAPS = 1 << SEL_W;

  logic [TAPS-1:0]  tap;
  logic             ext_rise, ext_fall;
  logic [CNT_W-1:0] cnt_arr [NUM_TMR];
  reg_e             wr_reg;

  assign wr_reg = reg_e'(wr_addr[1:0]);

  drt_prescaler #(.PRE_BASE(PRE_BASE), .NUM_TAPS(TAPS)) u_pre (
    .clk(clk), .rst_n(rst_n), .tap(tap));

  drt_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_cnt), .rise(ext_rise), .fall(ext_fall));

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic sel_wr;
    assign sel_wr = wr_en && (wr_addr[ADDR_W-1] == 1'(i));
    drt_timer_core #(.CNT_W(CNT_W), .NUM_TAPS(TAPS), .HAS_EXT(i == 0)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (sel_wr),
      .wr_reg   (wr_reg),
      .wr_data  (wr_data),
      .tap      (tap),
      .casc_stb (casc_stb),
      .ext_rise ((i == 0) ? ext_rise : 1'b0),
      .ext_fall ((i == 0) ? ext_fall : 1'b0),
      .cnt      (cnt_arr[i]),
      .tick     (tick[i]),
      .ovf      (ovf[i]));
  end

  assign cnt0 = cnt_arr[0];
  assign cnt1 = cnt_arr[1];
endmodule

// File: rtl/drt_checker.sv
module drt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1,
  input logic [1:0]       tick,
  input logic [1:0]       ovf
);
  logic [CNT_W-1:0] cnt_v  [2];
  logic [CNT_W-1:0] rld_sh [2];
  logic [1:0]       run_sh, cntwr, rldwr, ctlwr;

  assign cnt_v[0] = cnt0;
  assign cnt_v[1] = cnt1;

  for (genvar i = 0; i < 2; i++) begin : g_chk
    assign cntwr[i] = wr_en && (wr_addr[2] == 1'(i)) && (wr_addr[1:0] == 2'd0);
    assign rldwr[i] = wr_en && (wr_addr[2] == 1'(i)) && (wr_addr[1:0] == 2'd1);
    assign ctlwr[i] = wr_en && (wr_addr[2] == 1'(i)) && (wr_addr[1:0] == 2'd2);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rld_sh[i] <= '0;
        run_sh[i] <= 1'b0;
      end else begin
        if (rldwr[i]) rld_sh[i] <= wr_data;
        if (ctlwr[i]) run_sh[i] <= wr_data[0];
      end
    end

    AST_OVF_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      ovf[i] |-> tick[i]); // R5
    AST_OVF_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      ovf[i] |-> (cnt_v[i] == {CNT_W{1'b1}})); // R5
    AST_RELOAD_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf[i] && !cntwr[i]) |=> (cnt_v[i] == $past(rld_sh[i]))); // R6
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[i] && !ovf[i] && !cntwr[i] && (cnt_v[i] != {CNT_W{1'b1}}))
        |=> (cnt_v[i] == $past(cnt_v[i]) + 1'b1)); // R4
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cntwr[i] |=> (cnt_v[i] == $past(wr_data))); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick[i] && !cntwr[i]) |=> $stable(cnt_v[i])); // R8
    AST_RUN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      !run_sh[i] |-> !tick[i]); // R8
  end
endmodule

bind dual_reload_timer drt_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/dual_reload_timer_tb.sv
`timescale 1ns/1ps
module dual_reload_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, casc_stb, ext_cnt;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data, cnt0, cnt1;
  logic [1:0]  tick, ovf;

  always #5 clk = ~clk;

  dual_reload_timer u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .casc_stb(casc_stb), .ext_cnt(ext_cnt), .cnt0(cnt0), .cnt1(cnt1),
    .tick(tick), .ovf(ovf));

  int n_chk = 0, n_err = 0;
  int tick_seen[2], ovf_seen[2];
  bit done = 0;

  // behavioural reference model
  int m_pre, m_cnt[2], m_rld[2], m_src[2], m_div[2], m_edg[2];
  bit m_run[2], s1, s2, s3;

  function automatic bit m_pulse(int i);
    int n = 8 << m_div[i];
    bit r = s2 && !s3, f = !s2 && s3;
    case (m_src[i])
      0: return (m_pre % n) == n - 1;
      1: return casc_stb;
      2: if (i != 0) return 0;
         else return (m_edg[i] == 1 && r) || (m_edg[i] == 2 && f) || (m_edg[i] == 3 && (r || f));
      default: return 0;
    endcase
  endfunction

  function automatic bit m_tick(int i);
    return m_run[i] && m_pulse(i);
  endfunction

  function automatic bit m_wr(int i, int r);
    return wr_en && (int'(wr_addr[2]) == i) && (int'(wr_addr[1:0]) == r);
  endfunction

  function automatic bit m_ovf(int i);
    return m_tick(i) && m_cnt[i] == 65535 && !m_wr(i, 0);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; s1 = 0; s2 = 0; s3 = 0;
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = 0; m_rld[i] = 0; m_run[i] = 0; m_src[i] = 0; m_div[i] = 0; m_edg[i] = 0;
      end
    end else begin
      bit t[2];
      for (int i = 0; i < 2; i++) t[i] = m_tick(i);
      for (int i = 0; i < 2; i++) begin
        if (m_wr(i, 0)) m_cnt[i] = int'(wr_data);
        else if (t[i]) m_cnt[i] = (m_cnt[i] == 65535) ? m_rld[i] : m_cnt[i] + 1;
        if (m_wr(i, 1)) m_rld[i] = int'(wr_data);
        if (m_wr(i, 2)) begin
          m_run[i] = wr_data[0]; m_src[i] = int'(wr_data[2:1]);
          m_div[i] = int'(wr_data[5:3]); m_edg[i] = int'(wr_data[7:6]);
        end
      end
      s3 = s2; s2 = s1; s1 = ext_cnt;
      m_pre = (m_pre + 1) % 1024;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(cnt0) == m_cnt[0], "R4 cnt0", int'(cnt0), m_cnt[0]);
      chk(int'(cnt1) == m_cnt[1], "R12 cnt1", int'(cnt1), m_cnt[1]);
      for (int i = 0; i < 2; i++) begin
        chk(tick[i] == m_tick(i), "R3 tick", int'(tick[i]), int'(m_tick(i)));
        chk(ovf[i] == m_ovf(i), "R5 ovf", int'(ovf[i]), int'(m_ovf(i)));
        if (tick[i]) tick_seen[i]++;
        if (ovf[i])  ovf_seen[i]++;
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    idle(1);
    wr_en = 0;
  endtask

  task automatic clr();
    tick_seen = '{0, 0}; ovf_seen = '{0, 0};
  endtask

  task automatic casc(int gap);
    casc_stb = 1; idle(1); casc_stb = 0; idle(gap);
  endtask

  task automatic ext_toggles(int n);
    for (int k = 0; k < n; k++) begin
      ext_cnt = ~ext_cnt; idle(5);
    end
  endtask

  initial begin
    #1500000;
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int v;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; casc_stb = 0; ext_cnt = 0;
    idle(3);
    @(negedge clk);
    chk(cnt0 == 0 && cnt1 == 0, "R1 counters", int'({cnt0, cnt1}), 0);
    chk(tick == 0 && ovf == 0, "R1 strobes", int'({tick, ovf}), 0);
    @(posedge clk); #2; rst_n = 1;
    idle(2);

    // R3 prescaler div 8 with R5/R2 reload path on timer 0
    wr(3'd1, 16'hFFF0); wr(3'd0, 16'hFFFA); wr(3'd2, 16'h0001);
    clr(); idle(64);
    chk(tick_seen[0] == 8, "R3 div8 strobes", tick_seen[0], 8);
    chk(ovf_seen[0] == 1, "R5 one overflow", ovf_seen[0], 1);
    chk(cnt0 == 16'hFFF2, "R5 reload value", int'(cnt0), 16'hFFF2);

    // R8 run bit clear
    wr(3'd2, 16'h0000); v = int'(cnt0); clr(); idle(40);
    chk(int'(cnt0) == v && tick_seen[0] == 0, "R8 stopped", int'(cnt0), v);

    // R12 independence: timer 0 div 32, timer 1 stopped
    v = int'(cnt1);
    wr(3'd2, 16'h0011); clr(); idle(128);
    chk(tick_seen[0] == 4, "R12 div32 strobes", tick_seen[0], 4);
    chk(int'(cnt1) == v && tick_seen[1] == 0, "R12 timer1 idle", int'(cnt1), v);
    wr(3'd2, 16'h0000);

    // R11 source 3 and source 2 on timer 1 never count
    wr(3'd2, 16'h0007); wr(3'd6, 16'h0045); clr();
    ext_toggles(6); casc(3);
    chk(tick_seen[0] == 0 && tick_seen[1] == 0, "R11 no count", tick_seen[0] + tick_seen[1], 0);

    // R9 cascade source on timer 1
    wr(3'd2, 16'h0000); wr(3'd4, 16'h0010); wr(3'd6, 16'h0003); clr();
    casc(0); casc(2); casc(1); casc(4); casc(0);
    chk(cnt1 == 16'h0015 && tick_seen[1] == 5, "R9 cascade", int'(cnt1), 16'h0015);

    // R6 reload write leaves count alone
    wr(3'd5, 16'h1234); idle(1);
    chk(cnt1 == 16'h0015, "R6 count unchanged", int'(cnt1), 16'h0015);
    wr(3'd4, 16'hFFFE); clr(); casc(1); casc(1);
    chk(cnt1 == 16'h1234 && ovf_seen[1] == 1, "R6 new reload used", int'(cnt1), 16'h1234);

    // R7 counter write collides with overflow strobe
    wr(3'd4, 16'hFFFF);
    casc_stb = 1; wr_en = 1; wr_addr = 3'd4; wr_data = 16'h0055;
    @(negedge clk);
    chk(tick[1] == 1 && ovf[1] == 0, "R7 strobes", int'({tick[1], ovf[1]}), 2);
    @(posedge clk); #2; casc_stb = 0; wr_en = 0;
    chk(cnt1 == 16'h0055, "R7 write wins", int'(cnt1), 16'h0055);

    // R10 external pin latency and edge modes on timer 0
    wr(3'd6, 16'h0000); wr(3'd0, 16'h0000); wr(3'd2, 16'h0045);
    ext_cnt = 1;
    @(negedge clk); chk(tick[0] == 0, "R10 latency c0", int'(tick[0]), 0);
    @(negedge clk); chk(tick[0] == 0, "R10 latency c1", int'(tick[0]), 0);
    @(negedge clk); chk(tick[0] == 1, "R10 latency c2", int'(tick[0]), 1);
    idle(4); ext_cnt = 0; idle(5);
    clr(); ext_toggles(6);
    chk(tick_seen[0] == 3, "R10 rising", tick_seen[0], 3);
    wr(3'd2, 16'h0085); clr(); ext_toggles(6);
    chk(tick_seen[0] == 3, "R10 falling", tick_seen[0], 3);
    wr(3'd2, 16'h00C5); clr(); ext_toggles(6);
    chk(tick_seen[0] == 6, "R10 both", tick_seen[0], 6);
    wr(3'd2, 16'h0005); clr(); ext_toggles(6);
    chk(tick_seen[0] == 0, "R10 none", tick_seen[0], 0);

    // R2 address code 3 ignored
    wr(3'd2, 16'h0000); v = int'(cnt0);
    wr(3'd3, 16'h0001); wr(3'd7, 16'h0001); clr(); idle(40);
    chk(int'(cnt0) == v && tick_seen[0] == 0 && tick_seen[1] == 0, "R2 unused code", int'(cnt0), v);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule